// File: doc/BRIEF.md
# Chained Wide Transfer Byte Joiner

This block packs a byte stream into 16-bit words for a wide data path, in both directions. A send lane takes bytes from the internal side and produces words for the wide bus. A receive lane takes bytes captured from the wide bus and produces words for the internal side. Bytes are paired in little-endian order. A transfer can end on an odd byte. With chained mode off, that last byte goes out alone in a word whose upper byte is zero. With chained mode on, the byte is held in the lane. It then becomes the low byte of the first word of the next transfer in the same direction, so the wide bus only ever carries full words.

Chained mode is a single control bit. A chained block-move instruction strobe sets it and a plain block-move strobe clears it. A status byte exposes the chained bit, a send-hold flag and a receive-residue flag. Software can drop a held send byte by writing a 1 to the send-hold flag's position. A receive byte or a narrow send byte also drops it.

Top module: `chain_byte_joiner`

## Requirements
- R1: After reset, both word-valid outputs are low, the status byte is 0x00 and neither lane holds a byte.
- R2: A pulse on `chain_set_i` sets the chained bit (status bit 6). A pulse on `chain_clr_i` alone clears it. When both pulse in the same cycle the bit ends up set.
- R3: On a wide transfer, the first byte of each pair is kept. The second byte then produces a word on the lane's output one cycle after it is accepted: the first byte on bits 7:0 and the second on bits 15:8.
- R4: With chained mode off, an odd last byte of a wide transfer produces a word with bits 15:8 equal to 0x00, and the lane holds nothing afterwards.
- R5: With chained mode on, an odd last byte of a wide send produces no word. The byte is held and status bit 3 (send-hold flag) reads 1.
- R6: The first byte of the next send after a held byte produces the word {new byte, held byte}, and status bit 3 returns to 0.
- R7: A status write with bit 3 set clears the send-hold flag and drops the held byte, so the next send pairs afresh. A write with bit 3 clear has no effect. The written bit is not stored: bit 3 only ever reads the flag.
- R8: Any byte accepted on the receive lane clears the send-hold flag and drops the held send byte.
- R9: A narrow byte (`wide_i` low) on either lane produces the word {0x00, byte} one cycle later. It also drops any byte held in that lane, so a narrow send clears the send-hold flag.
- R10: With chained mode on, an odd last byte of a wide receive is held and status bit 0 (receive-residue flag) reads 1. The next received byte produces {new byte, residue} and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_set_i | input | 1 | Chained block-move instruction strobe |
| chain_clr_i | input | 1 | Plain block-move instruction strobe |
| wide_i | input | 1 | Current transfer is wide (1) or narrow (0) |
| snd_vld_i | input | 1 | Send byte accepted this cycle |
| snd_byte_i | input | 8 | Send byte |
| snd_last_i | input | 1 | Send byte is the last of its transfer |
| snd_word_vld_o | output | 1 | Send word valid |
| snd_word_o | output | 16 | Send word toward the wide bus |
| rcv_vld_i | input | 1 | Receive byte accepted this cycle |
| rcv_byte_i | input | 8 | Receive byte |
| rcv_last_i | input | 1 | Receive byte is the last of its transfer |
| rcv_word_vld_o | output | 1 | Receive word valid |
| rcv_word_o | output | 16 | Receive word toward the internal side |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Status write data; bit 3 set clears the send-hold flag |
| status_o | output | 8 | Bit 6 chained mode, bit 3 send-hold flag, bit 0 receive-residue flag |

## Verification
Directed transfers of even and odd length, with chained mode both off and on, separate a padded word from a held byte. Back-to-back chained sends show that the carried byte lands in the low half of the next word and not the high half. Clear writes with and without bit 3 set, receive bytes and narrow bytes are each placed while a send byte is held, so each drop path is tested on its own. Random transfers with random length, direction, width, mode strobes and clear writes are then compared word by word, and status after every byte, against a byte-level model in the bench.

// File: rtl/joiner_pkg.sv
package joiner_pkg;
   localparam int unsigned JN_BYTE_W     = 8;
   localparam int unsigned JN_REG_W      = 8;
   localparam int unsigned JN_SEND_BIT   = 3;
   localparam int unsigned JN_RESID_BIT  = 0;
   localparam int unsigned JN_CHAIN_BIT  = 6;

   typedef enum logic [1:0] {
      SRC_FLAG_NONE  = 2'd0,
      SRC_FLAG_SEND  = 2'd1,
      SRC_FLAG_RESID = 2'd2,
      SRC_FLAG_CHAIN = 2'd3
   } status_src_e;

   function automatic status_src_e status_src(input int unsigned bit_idx,
                                              input int unsigned send_bit,
                                              input int unsigned resid_bit,
                                              input int unsigned chain_bit);
      if (bit_idx == send_bit)  return SRC_FLAG_SEND;
      if (bit_idx == resid_bit) return SRC_FLAG_RESID;
      if (bit_idx == chain_bit) return SRC_FLAG_CHAIN;
      return SRC_FLAG_NONE;
   endfunction
endpackage

// File: rtl/jn_chain_ctl.sv
module jn_chain_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic chain_o
);
   logic chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     chain_q <= 1'b0;
      else if (set_i) chain_q <= 1'b1;
      else if (clr_i) chain_q <= 1'b0;
   end

   assign chain_o = chain_q;

   p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> chain_o);
   p_clr_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !chain_o);
endmodule

// File: rtl/jn_pair_lane.sv
module jn_pair_lane #(
   parameter int unsigned BYTE_W  = 8,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              last_i,
   input  logic              wide_i,
   input  logic              chain_i,
   input  logic              flush_i,
   output logic              word_vld_o,
   output logic [WORD_W-1:0] word_o,
   output logic              carry_o
);
   localparam logic [BYTE_W-1:0] PAD = '0;

   logic              pend_q, carry_q;
   logic [BYTE_W-1:0] hold_q;
   logic              pend_d, carry_d;
   logic [BYTE_W-1:0] hold_d;
   logic              out_vld;
   logic [WORD_W-1:0] out_word;

   always_comb begin
      pend_d   = pend_q;
      carry_d  = carry_q;
      hold_d   = hold_q;
      out_vld  = 1'b0;
      out_word = '0;
      if (valid_i) begin
         if (!wide_i) begin
            out_vld  = 1'b1;
            out_word = {PAD, byte_i};
            pend_d   = 1'b0;
            carry_d  = 1'b0;
         end else if (pend_q) begin
            out_vld  = 1'b1;
            out_word = {byte_i, hold_q};
            pend_d   = 1'b0;
            carry_d  = 1'b0;
         end else if (last_i) begin
            if (chain_i) begin
               pend_d  = 1'b1;
               carry_d = 1'b1;
               hold_d  = byte_i;
            end else begin
               out_vld  = 1'b1;
               out_word = {PAD, byte_i};
            end
         end else begin
            pend_d = 1'b1;
            hold_d = byte_i;
         end
      end
      if (flush_i) begin
         pend_d  = 1'b0;
         carry_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         carry_q <= 1'b0;
         hold_q  <= '0;
      end else begin
         pend_q  <= pend_d;
         carry_q <= carry_d;
         hold_q  <= hold_d;
      end
   end

   assign carry_o = carry_q;

   generate
      if (OUT_REG) begin : g_out_reg
         logic              vld_q;
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               word_q <= '0;
            end else begin
               vld_q  <= out_vld;
               word_q <= out_vld ? out_word : word_q;
            end
         end
         assign word_vld_o = vld_q;
         assign word_o     = word_q;

         p_word_follows_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
            word_vld_o |-> $past(valid_i));
         p_narrow_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (word_vld_o && $past(!wide_i)) |-> (word_o[WORD_W-1:BYTE_W] == PAD));
      end else begin : g_out_comb
         assign word_vld_o = out_vld;
         assign word_o     = out_word;
      end
   endgenerate

   p_carry_needs_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carry_o) |-> $past(valid_i && last_i && chain_i && wide_i));
   p_carry_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !carry_o);
endmodule

// File: rtl/chain_byte_joiner.sv
module chain_byte_joiner
   import joiner_pkg::*;
#(
   parameter int unsigned BYTE_W    = JN_BYTE_W,
   parameter int unsigned REG_W     = JN_REG_W,
   parameter int unsigned SEND_BIT  = JN_SEND_BIT,
   parameter int unsigned RESID_BIT = JN_RESID_BIT,
   parameter int unsigned CHAIN_BIT = JN_CHAIN_BIT,
   parameter bit          OUT_REG   = 1'b1,
   localparam int unsigned WORD_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chain_set_i,
   input  logic              chain_clr_i,
   input  logic              wide_i,
   input  logic              snd_vld_i,
   input  logic [BYTE_W-1:0] snd_byte_i,
   input  logic              snd_last_i,
   output logic              snd_word_vld_o,
   output logic [WORD_W-1:0] snd_word_o,
   input  logic              rcv_vld_i,
   input  logic [BYTE_W-1:0] rcv_byte_i,
   input  logic              rcv_last_i,
   output logic              rcv_word_vld_o,
   output logic [WORD_W-1:0] rcv_word_o,
   input  logic              reg_wr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  status_o
);
   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("BYTE_W must be at least 2");
      end
      if (SEND_BIT >= REG_W || RESID_BIT >= REG_W || CHAIN_BIT >= REG_W) begin : g_bad_pos
         $error("status bit positions must fit in REG_W");
      end
      if (SEND_BIT == RESID_BIT || SEND_BIT == CHAIN_BIT || RESID_BIT == CHAIN_BIT) begin : g_dup_pos
         $error("status bit positions must be distinct");
      end
   endgenerate

   logic chain;
   logic snd_carry, rcv_carry;
   logic wr_clear;
   logic snd_flush;
   logic unused_wdata;

   assign wr_clear     = reg_wr_i & reg_wdata_i[SEND_BIT];
   assign unused_wdata = ^reg_wdata_i;
   assign snd_flush    = wr_clear | rcv_vld_i;

   jn_chain_ctl u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (chain_set_i),
      .clr_i   (chain_clr_i),
      .chain_o (chain)
   );

   jn_pair_lane #(.BYTE_W(BYTE_W), .OUT_REG(OUT_REG)) u_snd_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (snd_vld_i),
      .byte_i     (snd_byte_i),
      .last_i     (snd_last_i),
      .wide_i     (wide_i),
      .chain_i    (chain),
      .flush_i    (snd_flush),
      .word_vld_o (snd_word_vld_o),
      .word_o     (snd_word_o),
      .carry_o    (snd_carry)
   );

   jn_pair_lane #(.BYTE_W(BYTE_W), .OUT_REG(OUT_REG)) u_rcv_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (rcv_vld_i),
      .byte_i     (rcv_byte_i),
      .last_i     (rcv_last_i),
      .wide_i     (wide_i),
      .chain_i    (chain),
      .flush_i    (1'b0),
      .word_vld_o (rcv_word_vld_o),
      .word_o     (rcv_word_o),
      .carry_o    (rcv_carry)
   );

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_status
         localparam status_src_e SRC = status_src(b, SEND_BIT, RESID_BIT, CHAIN_BIT);
         if (SRC == SRC_FLAG_SEND) begin : g_send
            assign status_o[b] = snd_carry;
         end else if (SRC == SRC_FLAG_RESID) begin : g_resid
            assign status_o[b] = rcv_carry;
         end else if (SRC == SRC_FLAG_CHAIN) begin : g_chain
            assign status_o[b] = chain;
         end else begin : g_zero
            assign status_o[b] = 1'b0;
         end
      end
   endgenerate

   p_rcv_clears_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_vld_i |=> !status_o[SEND_BIT]);
   p_wr_clears_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_wdata_i[SEND_BIT]) |=> !status_o[SEND_BIT]);
   p_send_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[SEND_BIT]) |-> $past(snd_vld_i && snd_last_i && status_o[CHAIN_BIT]));
   p_resid_flag_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[RESID_BIT]) |-> $past(rcv_vld_i && rcv_last_i && status_o[CHAIN_BIT]));
endmodule

// File: tb/chain_byte_joiner_tb.sv
module chain_byte_joiner_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chain_set_i = 0, chain_clr_i = 0, wide_i = 1;
   logic        snd_vld_i = 0, snd_last_i = 0, rcv_vld_i = 0, rcv_last_i = 0;
   logic [7:0]  snd_byte_i = 0, rcv_byte_i = 0;
   logic        snd_word_vld_o, rcv_word_vld_o;
   logic [15:0] snd_word_o, rcv_word_o;
   logic        reg_wr_i = 0;
   logic [7:0]  reg_wdata_i = 0;
   logic [7:0]  status_o;

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model state
   bit         m_chain;
   bit         m_spend, m_scarry, m_rpend, m_rcarry;
   logic [7:0] m_sbyte, m_rbyte;
   logic [15:0] last_word;

   always #5 clk = ~clk;

   chain_byte_joiner u_dut (
      .clk(clk), .rst_n(rst_n), .chain_set_i(chain_set_i), .chain_clr_i(chain_clr_i),
      .wide_i(wide_i), .snd_vld_i(snd_vld_i), .snd_byte_i(snd_byte_i), .snd_last_i(snd_last_i),
      .snd_word_vld_o(snd_word_vld_o), .snd_word_o(snd_word_o),
      .rcv_vld_i(rcv_vld_i), .rcv_byte_i(rcv_byte_i), .rcv_last_i(rcv_last_i),
      .rcv_word_vld_o(rcv_word_vld_o), .rcv_word_o(rcv_word_o),
      .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .status_o(status_o)
   );

   function automatic logic [15:0] f_join(input logic [7:0] hi, input logic [7:0] lo);
      return {hi, lo};
   endfunction

   function automatic logic [7:0] f_status(input bit ch, input bit sc, input bit rc);
      logic [7:0] s;
      s = 8'h00;
      s[6] = ch;
      s[3] = sc;
      s[0] = rc;
      return s;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one byte through the model; returns expected word valid and word
   task automatic model_byte(input bit rcv, input logic [7:0] b, input bit last, input bit wide,
                             output bit ev, output logic [15:0] ew);
      bit pend, carry;
      logic [7:0] hb;
      ev = 0; ew = 16'h0;
      pend  = rcv ? m_rpend  : m_spend;
      carry = rcv ? m_rcarry : m_scarry;
      hb    = rcv ? m_rbyte  : m_sbyte;
      if (!wide) begin
         ev = 1; ew = f_join(8'h00, b); pend = 0; carry = 0;
      end else if (pend) begin
         ev = 1; ew = f_join(b, hb); pend = 0; carry = 0;
      end else if (last) begin
         if (m_chain) begin pend = 1; carry = 1; hb = b; end
         else begin ev = 1; ew = f_join(8'h00, b); end
      end else begin
         pend = 1; hb = b;
      end
      if (rcv) begin
         m_rpend = pend; m_rcarry = carry; m_rbyte = hb;
         m_spend = 0; m_scarry = 0;
      end else begin
         m_spend = pend; m_scarry = carry; m_sbyte = hb;
      end
   endtask

   task automatic drive_byte(input bit rcv, input logic [7:0] b, input bit last, input bit wide,
                             input string req);
      bit ev;
      logic [15:0] ew;
      @(negedge clk);
      wide_i = wide;
      if (rcv) begin rcv_vld_i = 1; rcv_byte_i = b; rcv_last_i = last; end
      else     begin snd_vld_i = 1; snd_byte_i = b; snd_last_i = last; end
      @(posedge clk);
      #2;
      snd_vld_i = 0; rcv_vld_i = 0; snd_last_i = 0; rcv_last_i = 0;
      model_byte(rcv, b, last, wide, ev, ew);
      if (rcv) begin
         check({req, " rcv valid"}, rcv_word_vld_o, ev);
         check({req, " snd idle"}, snd_word_vld_o, 0);
         if (ev) begin check({req, " rcv word"}, rcv_word_o, ew); last_word = rcv_word_o; end
      end else begin
         check({req, " snd valid"}, snd_word_vld_o, ev);
         check({req, " rcv idle"}, rcv_word_vld_o, 0);
         if (ev) begin check({req, " snd word"}, snd_word_o, ew); last_word = snd_word_o; end
      end
      check({req, " status"}, status_o, f_status(m_chain, m_scarry, m_rcarry));
   endtask

   task automatic xfer(input bit rcv, input bit wide, input int n, input logic [7:0] base,
                       input string req);
      for (int i = 0; i < n; i++)
         drive_byte(rcv, base + 8'(i), (i == n - 1), wide, req);
   endtask

   task automatic strobe(input bit set, input bit clr, input string req);
      @(negedge clk);
      chain_set_i = set; chain_clr_i = clr;
      @(posedge clk);
      #2;
      chain_set_i = 0; chain_clr_i = 0;
      if (set) m_chain = 1; else if (clr) m_chain = 0;
      check({req, " chain bit"}, status_o[6], m_chain);
   endtask

   task automatic reg_write(input logic [7:0] d, input string req);
      @(negedge clk);
      reg_wr_i = 1; reg_wdata_i = d;
      @(posedge clk);
      #2;
      reg_wr_i = 0; reg_wdata_i = 0;
      if (d[3]) begin m_spend = 0; m_scarry = 0; end
      check({req, " status after write"}, status_o, f_status(m_chain, m_scarry, m_rcarry));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      m_chain = 0; m_spend = 0; m_scarry = 0; m_rpend = 0; m_rcarry = 0;
      m_sbyte = 0; m_rbyte = 0; last_word = 0;
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check("R1 status", status_o, 8'h00);
      check("R1 snd valid", snd_word_vld_o, 0);
      check("R1 rcv valid", rcv_word_vld_o, 0);
      @(negedge clk);
      rst_n = 1;

      // R2 mode strobes
      strobe(1, 0, "R2 set");
      strobe(0, 1, "R2 clear");
      strobe(1, 1, "R2 both");
      strobe(0, 1, "R2 clear again");

      // R3 even wide send, unchained
      xfer(0, 1, 2, 8'hA1, "R3");
      check("R3 little-endian word", last_word, 16'hA2A1);
      // R4 odd send, unchained: padded
      xfer(0, 1, 3, 8'h10, "R4");
      check("R4 padded word", last_word, 16'h0012);
      check("R4 no hold", status_o[3], 0);

      // R5/R6 chained odd sends
      strobe(1, 0, "R5 set");
      xfer(0, 1, 3, 8'h30, "R5");
      check("R5 flag set", status_o[3], 1);
      drive_byte(0, 8'h55, 0, 1, "R6");
      check("R6 carried word", last_word, 16'h5532);
      check("R6 flag cleared", status_o[3], 0);
      drive_byte(0, 8'h56, 1, 1, "R6 tail");
      check("R6 tail held", status_o[3], 1);

      // R7 write clear
      reg_write(8'hF7, "R7 write without bit3");
      check("R7 flag kept", status_o[3], 1);
      reg_write(8'h08, "R7 write bit3");
      check("R7 flag cleared", status_o[3], 0);
      xfer(0, 1, 2, 8'h70, "R7 fresh pair");
      check("R7 fresh word", last_word, 16'h7170);
      check("R7 bit not stored", status_o[3], 0);

      // R8 receive clears send hold
      xfer(0, 1, 1, 8'h80, "R8 hold");
      check("R8 held", status_o[3], 1);
      strobe(0, 1, "R8 plain");
      xfer(1, 1, 2, 8'h90, "R8 rcv");
      check("R8 flag cleared", status_o[3], 0);

      // R9 narrow send clears hold
      strobe(1, 0, "R9 set");
      xfer(0, 1, 1, 8'hB0, "R9 hold");
      drive_byte(0, 8'hC3, 1, 0, "R9 narrow");
      check("R9 narrow word", last_word, 16'h00C3);
      check("R9 flag cleared", status_o[3], 0);

      // R10 receive residue
      xfer(1, 1, 3, 8'hD0, "R10");
      check("R10 residue flag", status_o[0], 1);
      drive_byte(1, 8'hE5, 0, 1, "R10 merge");
      check("R10 merged word", last_word, 16'hE5D2);
      check("R10 flag cleared", status_o[0], 0);
      drive_byte(1, 8'hE6, 1, 1, "R10 tail");

      // random mix: R3 R4 R5 R6 R7 R8 R9 R10
      for (int t = 0; t < 400; t++) begin
         int unsigned r;
         r = $urandom_range(0, 9);
         if (r == 0) strobe(1, 0, "R2 rand");
         else if (r == 1) strobe(0, 1, "R2 rand");
         else if (r == 2) reg_write(8'($urandom), "R7 rand");
         begin
            bit rcv, wide;
            int n;
            rcv  = $urandom_range(0, 1);
            wide = ($urandom_range(0, 7) != 0);
            n    = $urandom_range(1, 5);
            xfer(rcv, wide, n, 8'($urandom), "R3/R6/R8/R9/R10 rand");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule